// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits between the byte-level receive logic of a serial memory slave and its storage array. A write transaction opens with a starting address. Every data byte that follows lands in a 16-slot page latch. Only the slot index advances, so the transaction never leaves the page named by the upper address bits. A byte that arrives after the page is full lands on the oldest slot again.

When the Stop strobe arrives, the controller starts a self-timed write cycle, provided at least one byte was captured and write protection is off. The cycle first waits a parameterised number of timer ticks. It then sweeps all 16 slots of the page, in ascending order, once each. Only the slots that received a byte produce an array write, so the other bytes of the page keep their stored values. The busy flag covers the whole cycle, and while it is high all transaction inputs are ignored.

Top module: `pgwr_commit`

## Requirements
- R1: The first accepted byte goes to the start address. Every array write presents `mem_addr` = {page number (bits 10:4), slot (bits 3:0)}, with the byte data on `mem_wdata`.
- R2: Each accepted byte advances only the 4-bit slot index, and the index wraps from 15 to 0. The page bits stay fixed from the start of the transaction to the end of its commit.
- R3: When more than 16 bytes arrive before Stop, a later byte replaces the earlier byte in the same slot. Only the most recent value of each slot is written.
- R4: No array write happens before Stop. Array writes occur only while `busy` is high.
- R5: Slots that received no byte during the transaction produce no array write, so the array keeps their old contents.
- R6: If `wp` is high in the Stop cycle, no write cycle starts, `busy` stays low and the captured bytes are discarded.
- R7: A Stop with no captured byte starts no write cycle. A new `wr_begin` before Stop discards everything captured so far and restarts at the new address.
- R8: `busy` rises on the clock edge that samples a valid Stop. It stays high for CYCLE_TICKS ticks of `tick`, plus 16 slot-sweep cycles. It falls on the edge that completes slot 15.
- R9: While `busy` is high, `wr_begin`, `byte_vld` and `stop_evt` have no effect.
- R10: During and right after reset, `busy` and `mem_we` are low.
- R11: When `wr_begin`, `stop_evt` and `byte_vld` coincide, `wr_begin` takes precedence over `stop_evt`, which takes precedence over `byte_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_begin | input | 1 | Opens a write transaction at `wr_addr` |
| wr_addr | input | 11 | Start address: page in bits 10:4, slot in bits 3:0 |
| byte_vld | input | 1 | One data byte is present on `byte_data` |
| byte_data | input | 8 | Data byte |
| stop_evt | input | 1 | Stop condition seen; ends the transaction |
| wp | input | 1 | Write protect, sampled with Stop |
| tick | input | 1 | Timebase pulse for the write-cycle timer |
| busy | output | 1 | Write cycle in progress |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 11 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The bench targets four failure modes:
- **Wrong wrap.** A page write that starts near the top of the page checks that the slot index wraps. A design that carried into the page bits would write to the next page.
- **Wrong overwrite.** A 20-byte burst checks that the slots filled first end up holding their replacement values. A design that kept the first value would write stale data.
- **Writes to untouched slots.** Partial pages check that no write is issued for an empty slot. A design that wrote garbage there would show an unexpected write.
- **Cycles that should not start.** The bench sends protected, empty and restarted transactions, and also sends Stop, Start and bytes while busy. A controller that launched a cycle in any of these cases would raise busy or issue writes that nothing expects.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  localparam int PG_ADDR_W = 11;
  localparam int PG_DATA_W = 8;
  localparam int PG_SLOT_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_HOLD  = 2'd2,
    ST_DRAIN = 2'd3
  } pg_state_e;
endpackage

// File: rtl/pgwr_latch.sv
module pgwr_latch #(
  parameter int ADDR_W = pgwr_pkg::PG_ADDR_W,
  parameter int DATA_W = pgwr_pkg::PG_DATA_W,
  parameter int SLOT_W = pgwr_pkg::PG_SLOT_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     open_i,
  input  logic [ADDR_W-1:0]        open_addr_i,
  input  logic                     put_i,
  input  logic [DATA_W-1:0]        put_data_i,
  input  logic                     clr_i,
  input  logic [SLOT_W-1:0]        rd_slot_i,
  output logic [ADDR_W-SLOT_W-1:0] page_o,
  output logic                     rd_mask_o,
  output logic [DATA_W-1:0]        rd_data_o,
  output logic                     any_o
);
  localparam int SLOTS  = 1 << SLOT_W;
  localparam int PAGE_W = ADDR_W - SLOT_W;

  logic [PAGE_W-1:0] page_q, page_d;
  logic [SLOT_W-1:0] ptr_q, ptr_d;
  logic [SLOTS-1:0]  mask_q, mask_d;
  logic [DATA_W-1:0] slot_q [SLOTS];
  logic              put_en;

  assign put_en = put_i && !open_i;

  always_comb begin
    page_d = page_q;
    ptr_d  = ptr_q;
    mask_d = mask_q;
    if (clr_i) begin
      mask_d = '0;
    end
    if (open_i) begin
      page_d = open_addr_i[ADDR_W-1:SLOT_W];
      ptr_d  = open_addr_i[SLOT_W-1:0];
      mask_d = '0;
    end else if (put_i) begin
      mask_d[ptr_q] = 1'b1;
      ptr_d         = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      ptr_q  <= '0;
      mask_q <= '0;
    end else begin
      page_q <= page_d;
      ptr_q  <= ptr_d;
      mask_q <= mask_d;
    end
  end

  // data slots carry no reset; the mask says which are meaningful
  always_ff @(posedge clk) begin
    if (put_en) begin
      slot_q[ptr_q] <= put_data_i;
    end
  end

  assign page_o    = page_q;
  assign rd_mask_o = mask_q[rd_slot_i];
  assign rd_data_o = slot_q[rd_slot_i];
  assign any_o     = |mask_q;

  // R2: slot pointer wraps inside the page
  p_ptr_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (put_en && ptr_q == {SLOT_W{1'b1}}) |=> (ptr_q == '0));

  // R7: opening a transaction forgets earlier bytes
  p_open_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    open_i |=> !any_o);
endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
  parameter int TICKS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign done_o  = run_i && tick_i && at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      cnt_d = at_last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R8: count never passes the programmed length
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq #(
  parameter int SLOT_W = pgwr_pkg::PG_SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              begin_i,
  input  logic              put_i,
  input  logic              stop_i,
  input  logic              wp_i,
  input  logic              any_i,
  input  logic              timer_done_i,
  input  logic              slot_mask_i,
  output logic              open_o,
  output logic              put_ok_o,
  output logic              clr_o,
  output logic              run_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              we_o,
  output logic              busy_o
);
  import pgwr_pkg::*;

  pg_state_e         st_q, st_d;
  logic [SLOT_W-1:0] slot_q, slot_d;

  always_comb begin
    st_d     = st_q;
    slot_d   = slot_q;
    open_o   = 1'b0;
    put_ok_o = 1'b0;
    clr_o    = 1'b0;
    run_o    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (begin_i) begin
          open_o = 1'b1;
          st_d   = ST_FILL;
        end
      end
      ST_FILL: begin
        if (begin_i) begin
          open_o = 1'b1;
        end else if (stop_i) begin
          if (any_i && !wp_i) begin
            st_d = ST_HOLD;
          end else begin
            st_d  = ST_IDLE;
            clr_o = 1'b1;
          end
        end else if (put_i) begin
          put_ok_o = 1'b1;
        end
      end
      ST_HOLD: begin
        run_o  = 1'b1;
        slot_d = '0;
        if (timer_done_i) st_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        slot_d = slot_q + 1'b1;
        if (slot_q == {SLOT_W{1'b1}}) begin
          st_d  = ST_IDLE;
          clr_o = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      slot_q <= '0;
    end else begin
      st_q   <= st_d;
      slot_q <= slot_d;
    end
  end

  assign slot_o = slot_q;
  assign we_o   = (st_q == ST_DRAIN) && slot_mask_i;
  assign busy_o = (st_q == ST_HOLD) || (st_q == ST_DRAIN);

  // R6: protected Stop never launches a cycle
  p_wp_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FILL && stop_i && !begin_i && wp_i) |=> !busy_o);

  // R7: empty transaction never launches a cycle
  p_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FILL && stop_i && !begin_i && !any_i) |=> !busy_o);

  // R8: busy ends right after the last slot of the sweep
  p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> ($past(slot_q) == {SLOT_W{1'b1}}));
endmodule

// File: rtl/pgwr_commit.sv
module pgwr_commit #(
  parameter int ADDR_W      = pgwr_pkg::PG_ADDR_W,
  parameter int DATA_W      = pgwr_pkg::PG_DATA_W,
  parameter int SLOT_W      = pgwr_pkg::PG_SLOT_W,
  parameter int CYCLE_TICKS = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_begin,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop_evt,
  input  logic              wp,
  input  logic              tick,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int PAGE_W = ADDR_W - SLOT_W;

  logic              open_s, put_s, clr_s, run_s, any_s, done_s, mask_s;
  logic [SLOT_W-1:0] slot_s;
  logic [PAGE_W-1:0] page_s;

  pgwr_seq #(.SLOT_W(SLOT_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .begin_i(wr_begin), .put_i(byte_vld), .stop_i(stop_evt), .wp_i(wp),
    .any_i(any_s), .timer_done_i(done_s), .slot_mask_i(mask_s),
    .open_o(open_s), .put_ok_o(put_s), .clr_o(clr_s), .run_o(run_s),
    .slot_o(slot_s), .we_o(mem_we), .busy_o(busy)
  );

  pgwr_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_latch (
    .clk(clk), .rst_n(rst_n),
    .open_i(open_s), .open_addr_i(wr_addr),
    .put_i(put_s), .put_data_i(byte_data), .clr_i(clr_s),
    .rd_slot_i(slot_s), .page_o(page_s), .rd_mask_o(mask_s),
    .rd_data_o(mem_wdata), .any_o(any_s)
  );

  pgwr_timer #(.TICKS(CYCLE_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_i(run_s), .tick_i(tick), .done_o(done_s)
  );

  assign mem_addr = {page_s, slot_s};

  // R2 R9: page stays fixed for the whole write cycle
  p_page_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_addr[ADDR_W-1:SLOT_W]));

  // R4: array writes only happen inside a busy cycle
  p_we_in_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
endmodule

// File: tb/test_pgwr_commit.sv
module test_pgwr_commit;
  localparam int CLK_PERIOD = 10;
  localparam int TICKS      = 8;
  localparam int SWEEP      = 16;

  logic        clk, rst_n;
  logic        wr_begin, byte_vld, stop_evt, wp, tick;
  logic [10:0] wr_addr;
  logic [7:0]  byte_data;
  logic        busy, mem_we;
  logic [10:0] mem_addr;
  logic [7:0]  mem_wdata;

  int checks = 0;
  int fails  = 0;
  logic [18:0] exp_q[$];

  logic [7:0] m_val [16];
  logic       m_set [16];
  logic [6:0] m_page;
  logic [3:0] m_ptr;
  int         busy_run = 0;

  pgwr_commit #(.CYCLE_TICKS(TICKS)) i_pgwr_commit (
    .clk(clk), .rst_n(rst_n), .wr_begin(wr_begin), .wr_addr(wr_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .stop_evt(stop_evt),
    .wp(wp), .tick(tick), .busy(busy), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop expected writes as the design issues them
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 R5 unexpected write", {mem_addr, mem_wdata}, 0);
      end else begin
        logic [18:0] e;
        e = exp_q.pop_front();
        check({mem_addr, mem_wdata} == e, "R1 R2 R3 write", {mem_addr, mem_wdata}, e);
      end
    end
  end

  // busy duration monitor
  always @(negedge clk) begin
    if (rst_n && busy) busy_run++;
    else if (busy_run != 0) begin
      check(busy_run == TICKS + SWEEP, "R8 busy length", busy_run, TICKS + SWEEP);
      busy_run = 0;
    end
  end

  task automatic raw_begin(input logic [10:0] a);
    @(negedge clk); wr_begin = 1'b1; wr_addr = a;
    @(negedge clk); wr_begin = 1'b0;
  endtask

  task automatic raw_byte(input logic [7:0] d);
    @(negedge clk); byte_vld = 1'b1; byte_data = d;
    @(negedge clk); byte_vld = 1'b0;
  endtask

  task automatic raw_stop(input logic w);
    @(negedge clk); stop_evt = 1'b1; wp = w;
    @(negedge clk); stop_evt = 1'b0; wp = 1'b0;
  endtask

  task automatic t_begin(input logic [10:0] a);
    m_page = a[10:4]; m_ptr = a[3:0];
    for (int i = 0; i < 16; i++) m_set[i] = 1'b0;
    raw_begin(a);
  endtask

  task automatic t_byte(input logic [7:0] d);
    m_val[m_ptr] = d; m_set[m_ptr] = 1'b1; m_ptr = m_ptr + 4'd1;
    raw_byte(d);
  endtask

  // driver: Stop pushes the expected sweep into the scoreboard
  task automatic t_stop(input logic w, input string req);
    bit any;
    any = 1'b0;
    for (int i = 0; i < 16; i++) if (m_set[i]) any = 1'b1;
    if (any && !w)
      for (int i = 0; i < 16; i++)
        if (m_set[i]) exp_q.push_back({m_page, 4'(i), m_val[i]});
    raw_stop(w);
    if (any && !w) begin
      check(busy == 1'b1, "R8 busy rise", busy, 1);
    end else begin
      @(negedge clk);
      check(busy == 1'b0, req, busy, 0);
    end
  endtask

  task automatic wait_done();
    while (busy) @(negedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R5 pending writes", exp_q.size(), 0);
  endtask

  initial begin
    rst_n = 1'b0; wr_begin = 1'b0; byte_vld = 1'b0; stop_evt = 1'b0;
    wp = 1'b0; tick = 1'b1; wr_addr = '0; byte_data = '0;
    m_page = '0; m_ptr = '0;
    for (int i = 0; i < 16; i++) begin m_set[i] = 1'b0; m_val[i] = '0; end
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && mem_we == 1'b0, "R10 reset outputs", {busy, mem_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R10 after reset", busy, 0);

    // R1 single byte
    t_begin(11'h123); t_byte(8'hA5); t_stop(1'b0, "R1"); wait_done();

    // R2 wrap inside the page
    t_begin(11'h3FA);
    for (int i = 0; i < 10; i++) t_byte(8'h10 + 8'(i));
    t_stop(1'b0, "R2"); wait_done();

    // R3 overrun of 20 bytes
    t_begin(11'h500);
    for (int i = 0; i < 20; i++) t_byte(8'h40 + 8'(i));
    t_stop(1'b0, "R3"); wait_done();

    // R5 partial page near top of array
    t_begin(11'h7F5);
    for (int i = 0; i < 3; i++) t_byte(8'hC0 + 8'(i));
    t_stop(1'b0, "R5"); wait_done();

    // R6 write protect
    t_begin(11'h200); t_byte(8'h77); t_byte(8'h78);
    t_stop(1'b1, "R6 wp blocks cycle");
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R6 busy stays low", busy, 0);

    // R7 empty transaction and restart
    t_begin(11'h010); t_stop(1'b0, "R7 empty stop");
    t_begin(11'h020); t_byte(8'h01); t_byte(8'h02);
    t_begin(11'h034); t_byte(8'h99);
    t_stop(1'b0, "R7"); wait_done();

    // R11 begin beats stop in the same cycle
    t_begin(11'h060); t_byte(8'h55);
    @(negedge clk); wr_begin = 1'b1; wr_addr = 11'h068; stop_evt = 1'b1;
    @(negedge clk); wr_begin = 1'b0; stop_evt = 1'b0;
    check(busy == 1'b0, "R11 begin over stop", busy, 0);
    m_page = 7'h06; m_ptr = 4'h8;
    for (int i = 0; i < 16; i++) m_set[i] = 1'b0;
    t_byte(8'h66); t_stop(1'b0, "R11"); wait_done();

    // R9 traffic during busy is ignored
    t_begin(11'h0F0); t_byte(8'hE1);
    t_stop(1'b0, "R9");
    raw_begin(11'h000); raw_byte(8'hDD); raw_byte(8'hDE); raw_stop(1'b0);
    wait_done();
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R9 stray stop ignored", busy, 0);
    check(exp_q.size() == 0, "R9 no stray writes", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule